// File: doc/BRIEF.md
# Warp State Sampler

This block samples a scheduler's warp pool at a regular, programmable interval. Each warp slot supplies an active flag, an eligible flag, a program counter and a vector of stall-condition flags. At each sample point the block uses a free-running pseudo-random sequence to pick one active slot. It classifies that slot's scheduler state into a 4-bit code and places a record holding the slot index, the program counter and the state code on a valid/ready output stream.

The pick is independent of the slot the scheduler issues from on that cycle. The block also receives the scheduler's issue index for the same cycle, so it can tell whether the sampled warp was the one issued.

When the consumer holds off the stream, the block does not queue further samples. It discards them and counts each discarded sample in a saturating counter. A sample point at which no slot is active produces no record.

Top module: `warp_state_sampler`

## Requirements
- R1: While `sample_en` is high, a sample point occurs every `interval` cycles, for `interval` from 32 to 2048. The first sample point occurs so that `rec_valid` rises on the `interval`-th rising edge counted from the first edge at which `sample_en` is high.
- R2: The starting slot is given by the low log2(NUM_SLOTS) bits of a 16-bit Galois LFSR. The LFSR uses feedback mask 0xB400 (shift right, XOR the mask when the bit shifted out is 1), is seeded to 0xACE1 at reset, and advances once per sample point after its value is used. From the starting slot the block scans upward, wrapping past the top slot, and picks the first active slot; `rec_warp` carries that slot's index.
- R3: `rec_pc` carries the picked slot's program counter as it was on the sample cycle.
- R4: If `issue_valid` is high and `issue_idx` equals the picked slot, the state code is 0 (selected).
- R5: Otherwise, if the picked slot's eligible flag is high, the state code is 1 (eligible but not selected).
- R6: Otherwise the state code is 2+k, where k is the lowest set stall bit of the slot. Bit order 0..10: barrier wait, memory barrier, long scoreboard, short scoreboard, math throttle, no instruction, drain, sleeping, fixed-latency wait, dispatch, miscellaneous. If no stall bit is set, the code is 15.
- R7: A sample point with no active slot produces no record.
- R8: While `rec_valid` is high and `rec_ready` is low, the record and `rec_valid` hold. After an edge with `rec_ready` high and no new record, `rec_valid` is low.
- R9: A sample point with an active slot, taken while `rec_valid` is high and `rec_ready` is low, discards the sample and increments `drop_count`, which saturates at all ones.
- R10: After reset `rec_valid` is low and `drop_count` is zero.
- R11: While `sample_en` is low no sample point occurs, and the interval count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Sampling enable |
| interval | input | INTV_W | Cycles between sample points (32..2048) |
| warp_active | input | NUM_SLOTS | Slot holds a resident warp |
| warp_eligible | input | NUM_SLOTS | Slot is ready to issue |
| warp_pc | input | NUM_SLOTS*PC_W | Program counter per slot, slot s at bits s*PC_W upward |
| warp_stall | input | NUM_SLOTS*11 | Stall flags per slot, slot s at bits s*11 upward, bit order as in R6 |
| issue_valid | input | 1 | Scheduler issued this cycle |
| issue_idx | input | log2(NUM_SLOTS) | Slot the scheduler issued from |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_warp | output | log2(NUM_SLOTS) | Sampled slot index |
| rec_pc | output | PC_W | Sampled program counter |
| rec_state | output | 4 | Encoded scheduler state |
| drop_count | output | DROP_W | Saturating count of discarded samples |

## Verification
A sample point decided in one cycle shows up as a record, or as a `drop_count` increment, after the next rising edge, which is one register stage. The bench runs a behavioural reference model that advances on every rising edge from the same inputs. It compares every output at the following falling edge, where that one-edge latency has already passed. The directed checks count edges from the cycle `sample_en` is raised and check that `rec_valid` is low after edge `interval`-1 and high after edge `interval`. Drop checks are read after the third sample point of a stalled stream.

// File: rtl/wss_pkg.sv
package wss_pkg;
  localparam int NUM_STALL = 11;
  localparam int STATE_W   = 4;
  localparam logic [15:0] LFSR_SEED = 16'hACE1;
  localparam logic [15:0] LFSR_MASK = 16'hB400;

  typedef enum logic [STATE_W-1:0] {
    ST_SELECTED = 4'd0,
    ST_NOT_SEL  = 4'd1,
    ST_BARRIER  = 4'd2,
    ST_MEMBAR   = 4'd3,
    ST_LONG_SB  = 4'd4,
    ST_SHORT_SB = 4'd5,
    ST_MATH     = 4'd6,
    ST_NO_INST  = 4'd7,
    ST_DRAIN    = 4'd8,
    ST_SLEEP    = 4'd9,
    ST_WAIT     = 4'd10,
    ST_DISPATCH = 4'd11,
    ST_MISC     = 4'd12,
    ST_UNKNOWN  = 4'd15
  } wstate_e;
endpackage

// File: rtl/wss_interval_timer.sv
module wss_interval_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] interval,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q == interval - 1'b1);

  always_comb begin
    if (!en || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R1
endmodule

// File: rtl/wss_warp_picker.sv
module wss_warp_picker
  import wss_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 advance,
  input  logic [NUM_SLOTS-1:0] active,
  output logic [IDX_W-1:0]     pick_idx,
  output logic                 pick_found
);
  logic [15:0] lfsr_q, lfsr_d;
  logic [IDX_W-1:0] start_idx;

  assign start_idx = lfsr_q[IDX_W-1:0];

  always_comb begin
    if (advance)
      lfsr_d = lfsr_q[0] ? ((lfsr_q >> 1) ^ LFSR_MASK) : (lfsr_q >> 1);
    else
      lfsr_d = lfsr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= LFSR_SEED;
    else        lfsr_q <= lfsr_d;
  end

  always_comb begin
    logic [IDX_W-1:0] cand;
    pick_found = 1'b0;
    pick_idx   = start_idx;
    cand       = start_idx;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      cand = start_idx + IDX_W'(i);
      if (!pick_found && active[cand]) begin
        pick_found = 1'b1;
        pick_idx   = cand;
      end
    end
  end

  AST_PICK_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    pick_found |-> active[pick_idx]); // R2
  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 16'h0000); // R2
endmodule

// File: rtl/wss_state_classify.sv
module wss_state_classify
  import wss_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic                 issue_valid,
  input  logic [IDX_W-1:0]     issue_idx,
  input  logic [IDX_W-1:0]     slot_idx,
  input  logic                 eligible,
  input  logic [NUM_STALL-1:0] stall,
  output wstate_e              state
);
  always_comb begin
    state = ST_UNKNOWN;
    if (issue_valid && (issue_idx == slot_idx)) begin
      state = ST_SELECTED;
    end else if (eligible) begin
      state = ST_NOT_SEL;
    end else begin
      for (int k = NUM_STALL - 1; k >= 0; k--) begin
        if (stall[k]) state = wstate_e'(STATE_W'(k + 2));
      end
    end
  end
endmodule

// File: rtl/warp_state_sampler.sv
module warp_state_sampler
  import wss_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int PC_W      = 32,
  parameter int INTV_W    = 12,
  parameter int DROP_W    = 16,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int STALL_W  = NUM_SLOTS * NUM_STALL
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sample_en,
  input  logic [INTV_W-1:0]         interval,
  input  logic [NUM_SLOTS-1:0]      warp_active,
  input  logic [NUM_SLOTS-1:0]      warp_eligible,
  input  logic [NUM_SLOTS*PC_W-1:0] warp_pc,
  input  logic [STALL_W-1:0]        warp_stall,
  input  logic                      issue_valid,
  input  logic [IDX_W-1:0]          issue_idx,
  output logic                      rec_valid,
  input  logic                      rec_ready,
  output logic [IDX_W-1:0]          rec_warp,
  output logic [PC_W-1:0]           rec_pc,
  output logic [STATE_W-1:0]        rec_state,
  output logic [DROP_W-1:0]         drop_count
);
  logic                 tick;
  logic [IDX_W-1:0]     pick_idx;
  logic                 pick_found;
  logic [PC_W-1:0]      sel_pc;
  logic [NUM_STALL-1:0] sel_stall;
  logic                 sel_elig;
  wstate_e              sel_state;

  logic                 valid_q, valid_d;
  logic [IDX_W-1:0]     warp_q, warp_d;
  logic [PC_W-1:0]      pc_q, pc_d;
  wstate_e              state_q, state_d;
  logic [DROP_W-1:0]    drop_q, drop_d;
  logic                 take, slot_free, load_en, drop_en;

  wss_interval_timer #(.CNT_W(INTV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(sample_en), .interval(interval), .tick(tick)
  );

  wss_warp_picker #(.NUM_SLOTS(NUM_SLOTS)) u_picker (
    .clk(clk), .rst_n(rst_n), .advance(tick), .active(warp_active),
    .pick_idx(pick_idx), .pick_found(pick_found)
  );

  assign sel_pc    = warp_pc[pick_idx*PC_W +: PC_W];
  assign sel_stall = warp_stall[pick_idx*NUM_STALL +: NUM_STALL];
  assign sel_elig  = warp_eligible[pick_idx];

  wss_state_classify #(.IDX_W(IDX_W)) u_classify (
    .issue_valid(issue_valid), .issue_idx(issue_idx), .slot_idx(pick_idx),
    .eligible(sel_elig), .stall(sel_stall), .state(sel_state)
  );

  assign take      = tick && pick_found;
  assign slot_free = !valid_q || rec_ready;
  assign load_en   = take && slot_free;
  assign drop_en   = take && !slot_free;

  always_comb begin
    warp_d  = warp_q;
    pc_d    = pc_q;
    state_d = state_q;
    if (load_en) begin
      valid_d = 1'b1;
      warp_d  = pick_idx;
      pc_d    = sel_pc;
      state_d = sel_state;
    end else if (rec_ready) begin
      valid_d = 1'b0;
    end else begin
      valid_d = valid_q;
    end
    if (drop_en && (drop_q != {DROP_W{1'b1}})) drop_d = drop_q + 1'b1;
    else                                       drop_d = drop_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      warp_q  <= '0;
      pc_q    <= '0;
      state_q <= ST_UNKNOWN;
      drop_q  <= '0;
    end else begin
      valid_q <= valid_d;
      warp_q  <= warp_d;
      pc_q    <= pc_d;
      state_q <= state_d;
      drop_q  <= drop_d;
    end
  end

  assign rec_valid  = valid_q;
  assign rec_warp   = warp_q;
  assign rec_pc     = pc_q;
  assign rec_state  = state_q;
  assign drop_count = drop_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_warp) && $stable(rec_pc) && $stable(rec_state))); // R8
  AST_EMPTY_NO_REC: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !(|warp_active) && !(rec_valid && !rec_ready)) |=> !rec_valid); // R7
  AST_DROP_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (|warp_active) && rec_valid && !rec_ready && (drop_count != {DROP_W{1'b1}}))
      |=> (drop_count == $past(drop_count) + 1'b1)); // R9
  AST_SELECTED_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (|warp_active) && (!rec_valid || rec_ready))
      |=> ((rec_state == ST_SELECTED) == ($past(issue_valid) && (rec_warp == $past(issue_idx))))); // R4
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> !$rose(rec_valid)); // R11
endmodule

// File: tb/tb_warp_state_sampler.sv
`timescale 1ns/1ps
module tb_warp_state_sampler;
  localparam int NS = 16;
  localparam int PW = 32;
  localparam int IW = 12;
  localparam int DW = 16;
  localparam int NSTL = 11;
  localparam int XW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_en = 1'b0;
  logic [IW-1:0] interval = 12'd32;
  logic [NS-1:0] warp_active = '0;
  logic [NS-1:0] warp_eligible = '0;
  logic [NS*PW-1:0] warp_pc = '0;
  logic [NS*NSTL-1:0] warp_stall = '0;
  logic issue_valid = 1'b0;
  logic [XW-1:0] issue_idx = '0;
  logic rec_ready = 1'b1;
  logic rec_valid;
  logic [XW-1:0] rec_warp;
  logic [PW-1:0] rec_pc;
  logic [3:0] rec_state;
  logic [DW-1:0] drop_count;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  warp_state_sampler #(.NUM_SLOTS(NS), .PC_W(PW), .INTV_W(IW), .DROP_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .interval(interval),
    .warp_active(warp_active), .warp_eligible(warp_eligible), .warp_pc(warp_pc),
    .warp_stall(warp_stall), .issue_valid(issue_valid), .issue_idx(issue_idx),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_warp(rec_warp),
    .rec_pc(rec_pc), .rec_state(rec_state), .drop_count(drop_count)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_cnt;
  int m_lfsr;
  bit m_valid;
  int m_warp;
  longint m_pc;
  int m_state;
  int m_drop;

  function automatic int ref_state(int s);
    if (issue_valid && int'(issue_idx) == s) return 0;
    if (warp_eligible[s]) return 1;
    for (int k = 0; k < NSTL; k++)
      if (warp_stall[s*NSTL + k]) return 2 + k;
    return 15;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_lfsr = 'hACE1; m_valid = 0; m_warp = 0; m_pc = 0; m_state = 15; m_drop = 0;
    end else begin
      bit tk;
      bit found;
      int pick;
      int start;
      tk = sample_en && (m_cnt == int'(interval) - 1);
      if (!sample_en || tk) m_cnt = 0;
      else m_cnt = (m_cnt + 1) % 4096;
      found = 0; pick = 0;
      if (tk) begin
        start = m_lfsr % NS;
        for (int i = 0; i < NS; i++) begin
          if (!found && warp_active[(start + i) % NS]) begin
            found = 1; pick = (start + i) % NS;
          end
        end
        if (m_lfsr % 2 == 1) m_lfsr = (m_lfsr / 2) ^ 'hB400;
        else m_lfsr = m_lfsr / 2;
      end
      if (tk && found && (!m_valid || rec_ready)) begin
        m_valid = 1; m_warp = pick; m_pc = longint'(warp_pc[pick*PW +: PW]);
        m_state = ref_state(pick);
      end else begin
        if (tk && found && m_drop < 65535) m_drop++;
        if (rec_ready) m_valid = 0;
      end
    end
  end

  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      check(rec_valid == m_valid, "R8 rec_valid", rec_valid, m_valid);
      if (m_valid) begin
        check(int'(rec_warp) == m_warp, "R2 rec_warp", rec_warp, m_warp);
        check(longint'(rec_pc) == m_pc, "R3 rec_pc", rec_pc, m_pc);
        check(int'(rec_state) == m_state, "R6 rec_state", rec_state, m_state);
      end
      check(int'(drop_count) == m_drop, "R9 drop_count", drop_count, m_drop);
    end
  end

  task automatic only_slot(input int s, input bit elig, input logic [NSTL-1:0] stl,
                           input bit iv, input int ii);
    warp_active = '0; warp_eligible = '0; warp_stall = '0;
    warp_active[s] = 1'b1;
    warp_eligible[s] = elig;
    warp_stall[s*NSTL +: NSTL] = stl;
    for (int i = 0; i < NS; i++) warp_pc[i*PW +: PW] = 32'h1000_0000 + 32'(i * 16);
    issue_valid = iv; issue_idx = XW'(ii);
  endtask

  task automatic restart(input int ivl);
    @(negedge clk); sample_en = 1'b0;
    @(negedge clk); interval = IW'(ivl); sample_en = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rec_valid == 1'b0, "R10 reset rec_valid", rec_valid, 0);
    check(drop_count == '0, "R10 reset drop_count", drop_count, 0);
    cmp_on = 1;

    // R11: disabled, all active, nothing appears
    warp_active = '1;
    repeat (100) @(negedge clk);
    check(rec_valid == 1'b0, "R11 disabled no record", rec_valid, 0);

    // R1 + R4: timing of first record, issued slot
    only_slot(5, 1'b1, '0, 1'b1, 5);
    rec_ready = 1'b1;
    interval = 12'd32; sample_en = 1'b1;
    repeat (31) @(negedge clk);
    check(rec_valid == 1'b0, "R1 no record before interval", rec_valid, 0);
    @(negedge clk);
    check(rec_valid == 1'b1, "R1 record at interval", rec_valid, 1);
    check(rec_warp == 4'd5, "R2 only active slot", rec_warp, 5);
    check(rec_pc == 32'h1000_0050, "R3 pc of slot", rec_pc, 32'h1000_0050);
    check(rec_state == 4'd0, "R4 selected", rec_state, 0);
    @(negedge clk);
    check(rec_valid == 1'b0, "R8 cleared after accept", rec_valid, 0);

    // R5: eligible, scheduler issued elsewhere
    only_slot(9, 1'b1, 11'h7FF, 1'b1, 3);
    restart(32);
    repeat (32) @(negedge clk);
    check(rec_valid == 1'b1 && rec_state == 4'd1, "R5 not selected", rec_state, 1);

    // R6: priority, bits 4 and 7 set -> code 6
    only_slot(2, 1'b0, 11'b000_1001_0000, 1'b0, 2);
    restart(40);
    repeat (40) @(negedge clk);
    check(rec_valid == 1'b1 && rec_state == 4'd6, "R6 lowest stall bit wins", rec_state, 6);

    // R6: no flag -> 15
    only_slot(14, 1'b0, '0, 1'b1, 13);
    restart(32);
    repeat (32) @(negedge clk);
    check(rec_valid == 1'b1 && rec_state == 4'd15, "R6 no reason code", rec_state, 15);

    // R7: nothing active
    warp_active = '0;
    restart(32);
    repeat (70) @(negedge clk);
    check(rec_valid == 1'b0, "R7 empty pool no record", rec_valid, 0);

    // R9: stalled consumer, three sample points -> two drops
    only_slot(7, 1'b1, '0, 1'b0, 0);
    rec_ready = 1'b0;
    restart(32);
    repeat (96) @(negedge clk);
    check(rec_valid == 1'b1 && rec_warp == 4'd7, "R8 held while stalled", rec_warp, 7);
    check(drop_count == 16'd2, "R9 two drops", drop_count, 2);
    rec_ready = 1'b1;
    @(negedge clk);
    check(rec_valid == 1'b0, "R8 accepted", rec_valid, 0);

    // Random traffic, compared each cycle against the model
    for (int r = 0; r < 30; r++) begin
      restart(32 + $urandom_range(0, 32));
      for (int c = 0; c < 70; c++) begin
        warp_active = ($urandom_range(0, 4) == 0) ? '0 : NS'($urandom);
        warp_eligible = NS'($urandom);
        for (int i = 0; i < NS; i++) begin
          warp_pc[i*PW +: PW] = $urandom;
          warp_stall[i*NSTL +: NSTL] = NSTL'($urandom) & NSTL'($urandom);
        end
        issue_valid = $urandom_range(0, 1);
        issue_idx = XW'($urandom);
        rec_ready = ($urandom_range(0, 3) != 0);
        @(negedge clk);
      end
    end
    sample_en = 1'b0;
    repeat (5) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule